// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block holds the interrupt status and control state of a FIFO-based synchronous serial port. It takes four sources from the port datapath. Two are service requests derived from FIFO fill levels: the transmit side asks for more data, and the receive side asks to be drained. The other two are event strobes: a receive timeout and a receive overrun.

The two level-derived sources track the FIFO occupancy on every cycle and cannot be cleared by software. The two event sources are sticky. Each one latches when its strobe arrives and stays set until software writes a one to its bit in the clear register. A mask register enables each source on its own. Software can read the raw status and the masked status (raw AND mask) through a small register port. One interrupt line is the OR of all masked bits.

The register port has a 2-bit address, a write strobe, write data and combinational read data. Address 0 is the mask register, which can be read and written. Address 1 is the raw status and address 2 is the masked status; both are read-only. Address 3 is the write-only clear register. Every status vector uses one bit order: bit 0 overrun, bit 1 timeout, bit 2 receive service, bit 3 transmit service.

Top module: `sp_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the mask register reads 0, both sticky bits are clear, and the interrupt output is low.
- R2: Raw bit 3 (transmit service) is 1 whenever the transmit FIFO level is at most DEPTH/2, and 0 when it is above DEPTH/2.
- R3: Raw bit 2 (receive service) is 1 whenever the receive FIFO level is at least DEPTH/2, and 0 when it is below DEPTH/2.
- R4: A one-cycle receive timeout strobe sets raw bit 1 from the next clock edge on. The bit stays set after the strobe ends.
- R5: A one-cycle overrun strobe sets raw bit 0 from the next clock edge on. The bit stays set after the strobe ends.
- R6: Writing to address 3 clears each sticky bit (bits 0 and 1) whose write data bit is 1. Sticky bits written with 0 are kept. Bits 2 and 3 of that write have no effect on the status.
- R7: If a strobe and a clear of the same bit fall in the same cycle, the bit is set after the edge.
- R8: A write to address 0 loads the 4-bit mask, and a read of address 0 returns it. Writes to addresses 1 and 2 change neither the mask nor the status.
- R9: Address 1 reads the raw status, and address 2 reads the raw status ANDed with the mask.
- R10: The interrupt output is high exactly when at least one bit of the masked status is 1.
- R11: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_level | input | LVL_W | Current transmit FIFO occupancy |
| rx_level | input | LVL_W | Current receive FIFO occupancy |
| rx_timeout_evt | input | 1 | One-cycle strobe for a receive timeout |
| rx_overrun_evt | input | 1 | One-cycle strobe for a receive overrun |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The level sources are driven through each threshold, one step below it and one step above it. This shows whether the transmit and receive comparisons use the correct direction and whether each includes the half-depth point. The sticky sources are exercised in several ways. A lone strobe shows that a bit latches and holds. Selective clear writes show which bit each data bit reaches and that the level bits cannot be cleared. A strobe in the same cycle as its clear shows the priority. Mask patterns that cover only some of the active sources separate the raw read, the masked read and the interrupt line from each other.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;

    localparam int SRC_N   = 4;
    localparam int STICKY_N = 2;

    localparam int BIT_OVR = 0;
    localparam int BIT_TMO = 1;
    localparam int BIT_RXS = 2;
    localparam int BIT_TXS = 3;

    localparam logic [SRC_N-1:0] STICKY_SEL = 4'b0011;

    typedef enum logic [1:0] {
        ADDR_MASK = 2'd0,
        ADDR_RAW  = 2'd1,
        ADDR_MSKD = 2'd2,
        ADDR_CLR  = 2'd3
    } reg_addr_e;

    // packed order puts txs at bit 3 and ovr at bit 0
    typedef struct packed {
        logic txs;
        logic rxs;
        logic tmo;
        logic ovr;
    } src_vec_t;

    function automatic logic [SRC_N-1:0] src_flat(input src_vec_t s);
        return s;
    endfunction

    function automatic logic any_bit(input logic [SRC_N-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/sp_irq_level.sv
module sp_irq_level #(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_lvl_i,
    input  logic [LVL_W-1:0] rx_lvl_i,
    output logic             tx_svc_o,
    output logic             rx_svc_o
);
    localparam int HALF = DEPTH / 2;
    localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

    always_comb begin
        tx_svc_o = (tx_lvl_i <= HALF_L);
        rx_svc_o = (rx_lvl_i >= HALF_L);
    end
endmodule

// File: rtl/sp_irq_sticky.sv
module sp_irq_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q_r;

        always_ff @(posedge clk) begin
            if (rst)
                q_r <= 1'b0;
            else if (set_i[i])
                q_r <= 1'b1;
            else if (clr_i[i])
                q_r <= 1'b0;
        end

        assign q_o[i] = q_r;

        // R4 / R5: a strobe leaves the bit set on the next cycle
        a_r4_set_latches: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);

        a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
            (set_i[i] && clr_i[i]) |=> q_o[i]);

        a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);

        a_r5_holds: assert property (@(posedge clk) disable iff (rst)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
    end
endmodule

// File: rtl/sp_irq_regs.sv
module sp_irq_regs
    import sp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [SRC_N-1:0] wdata_i,
    input  logic [SRC_N-1:0] raw_i,
    output logic [SRC_N-1:0] mask_o,
    output logic [SRC_N-1:0] clr_o,
    output logic [SRC_N-1:0] rdata_o
);
    logic [SRC_N-1:0] mask_r;
    reg_addr_e        sel;

    assign sel = reg_addr_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst)
            mask_r <= '0;
        else if (wr_en_i && sel == ADDR_MASK)
            mask_r <= wdata_i;
    end

    always_comb begin
        clr_o = '0;
        if (wr_en_i && sel == ADDR_CLR)
            clr_o = wdata_i & STICKY_SEL;
    end

    always_comb begin
        unique case (sel)
            ADDR_MASK: rdata_o = mask_r;
            ADDR_RAW:  rdata_o = raw_i;
            ADDR_MSKD: rdata_o = raw_i & mask_r;
            default:   rdata_o = '0;
        endcase
    end

    assign mask_o = mask_r;

    a_r8_mask_stable: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && sel == ADDR_MASK) |=> $stable(mask_o));

    a_r8_mask_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel == ADDR_MASK) |=> (mask_o == $past(wdata_i)));

    always_comb begin
        if (!rst && sel == ADDR_CLR)
            a_r11_clr_reads_zero: assert (rdata_o == '0);
    end
endmodule

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl
    import sp_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_timeout_evt,
    input  logic             rx_overrun_evt,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [3:0]       reg_wdata,
    output logic [3:0]       reg_rdata,
    output logic             irq_o
);
    logic             tx_svc, rx_svc;
    logic [STICKY_N-1:0] stk_set, stk_clr, stk_q;
    logic [SRC_N-1:0] clr_vec, mask, raw;
    src_vec_t         src;

    sp_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
        .tx_lvl_i (tx_level),
        .rx_lvl_i (rx_level),
        .tx_svc_o (tx_svc),
        .rx_svc_o (rx_svc)
    );

    assign stk_set = {rx_timeout_evt, rx_overrun_evt};
    assign stk_clr = {clr_vec[BIT_TMO], clr_vec[BIT_OVR]};

    sp_irq_sticky #(.N(STICKY_N)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (stk_set),
        .clr_i (stk_clr),
        .q_o   (stk_q)
    );

    always_comb begin
        src.txs = tx_svc;
        src.rxs = rx_svc;
        src.tmo = stk_q[1];
        src.ovr = stk_q[0];
        raw     = src_flat(src);
    end

    sp_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (reg_wr_en),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .raw_i   (raw),
        .mask_o  (mask),
        .clr_o   (clr_vec),
        .rdata_o (reg_rdata)
    );

    assign irq_o = any_bit(raw & mask);

    a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

    a_r1_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> (stk_q == '0 && mask == '0));
endmodule

// File: tb/sp_irq_ctrl_test.sv
module sp_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic [LVL_W-1:0] tx_level;
    logic [LVL_W-1:0] rx_level;
    logic             rx_timeout_evt;
    logic             rx_overrun_evt;
    logic             reg_wr_en;
    logic [1:0]       reg_addr;
    logic [3:0]       reg_wdata;
    logic [3:0]       reg_rdata;
    logic             irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    sp_irq_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
        .rx_timeout_evt(rx_timeout_evt), .rx_overrun_evt(rx_overrun_evt),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(input bit tmo, input bit ovr);
        rx_timeout_evt = tmo;
        rx_overrun_evt = ovr;
        @(posedge clk);
        @(negedge clk);
        rx_timeout_evt = 1'b0;
        rx_overrun_evt = 1'b0;
    endtask

    task automatic idle_levels();
        tx_level = LVL_W'(DEPTH);
        rx_level = '0;
        #1;
    endtask

    task automatic t_reset();
        logic [3:0] d;
        idle_levels();
        rd(2'd0, d); chk("R1 mask after reset", d, 4'b0000);
        rd(2'd1, d); chk("R1 raw after reset", d, 4'b0000);
        chk("R1 irq after reset", {3'b0, irq_o}, 4'b0000);
    endtask

    task automatic t_tx_level();
        logic [3:0] d;
        idle_levels();
        tx_level = LVL_W'(DEPTH/2);     rd(2'd1, d); chk("R2 tx at half", d, 4'b1000);
        tx_level = LVL_W'(DEPTH/2 + 1); rd(2'd1, d); chk("R2 tx above half", d, 4'b0000);
        tx_level = '0;                  rd(2'd1, d); chk("R2 tx empty", d, 4'b1000);
        idle_levels();
    endtask

    task automatic t_rx_level();
        logic [3:0] d;
        idle_levels();
        rx_level = LVL_W'(DEPTH/2);     rd(2'd1, d); chk("R3 rx at half", d, 4'b0100);
        rx_level = LVL_W'(DEPTH/2 - 1); rd(2'd1, d); chk("R3 rx below half", d, 4'b0000);
        rx_level = LVL_W'(DEPTH);       rd(2'd1, d); chk("R3 rx full", d, 4'b0100);
        idle_levels();
    endtask

    task automatic t_sticky();
        logic [3:0] d;
        idle_levels();
        pulse(1'b1, 1'b0);
        rd(2'd1, d); chk("R4 timeout latched", d, 4'b0010);
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R4 timeout holds", d, 4'b0010);
        pulse(1'b0, 1'b1);
        rd(2'd1, d); chk("R5 overrun latched", d, 4'b0011);
    endtask

    task automatic t_clear();
        logic [3:0] d;
        wr(2'd3, 4'b0010);
        rd(2'd1, d); chk("R6 clear timeout only", d, 4'b0001);
        tx_level = '0; rx_level = LVL_W'(DEPTH);
        wr(2'd3, 4'b1100);
        rd(2'd1, d); chk("R6 level bits not clearable", d, 4'b1101);
        wr(2'd3, 4'b0001);
        rd(2'd1, d); chk("R6 clear overrun", d, 4'b1100);
        rd(2'd3, d); chk("R11 clear reg reads zero", d, 4'b0000);
        idle_levels();
    endtask

    task automatic t_set_wins();
        logic [3:0] d;
        reg_addr = 2'd3; reg_wdata = 4'b0011; reg_wr_en = 1'b1;
        rx_timeout_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0; rx_timeout_evt = 1'b0;
        rd(2'd1, d); chk("R7 set beats clear", d, 4'b0010);
        wr(2'd3, 4'b0011);
        rd(2'd1, d); chk("R7 cleanup", d, 4'b0000);
    endtask

    task automatic t_mask();
        logic [3:0] d;
        idle_levels();
        wr(2'd0, 4'b1010);
        rd(2'd0, d); chk("R8 mask readback", d, 4'b1010);
        wr(2'd1, 4'b0101);
        wr(2'd2, 4'b0101);
        rd(2'd0, d); chk("R8 ro writes ignored mask", d, 4'b1010);
        rd(2'd1, d); chk("R8 ro writes ignored raw", d, 4'b0000);
        chk("R10 irq low nothing pending", {3'b0, irq_o}, 4'b0000);
        pulse(1'b0, 1'b1);
        tx_level = '0; rx_level = LVL_W'(DEPTH);
        rd(2'd1, d); chk("R9 raw read", d, 4'b1101);
        rd(2'd2, d); chk("R9 masked read", d, 4'b1000);
        chk("R10 irq high", {3'b0, irq_o}, 4'b0001);
        tx_level = LVL_W'(DEPTH); #1;
        rd(2'd2, d); chk("R9 masked unmasked-only", d, 4'b0000);
        chk("R10 irq low when pending masked", {3'b0, irq_o}, 4'b0000);
        wr(2'd0, 4'b0001);
        chk("R10 irq from overrun", {3'b0, irq_o}, 4'b0001);
        wr(2'd3, 4'b0001);
        chk("R10 irq drops after clear", {3'b0, irq_o}, 4'b0000);
        idle_levels();
    endtask

    initial begin
        rst = 1'b1;
        rx_timeout_evt = 1'b0; rx_overrun_evt = 1'b0;
        reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        idle_levels();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_level();
        t_rx_level();
        t_sticky();
        t_clear();
        t_set_wins();
        t_mask();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule